// File: doc/BRIEF.md
# Divider-Tapped Interval Timer

This block is a register-mapped interval timer for a small 8-bit processor system. A 16-bit divider runs freely and advances by one on every system clock. A control register picks one divider bit and gates it with an enable bit. Each falling edge of that gated signal advances an 8-bit counter by one. When the counter would pass 0xFF it instead reloads from a modulo register and pulses the interrupt request for one clock.

The counter is fed by an edge detector on the gated tap, not by a clean prescaler output. Software actions that drop the gated signal from 1 to 0 therefore also count. Two such actions are turning the enable off and clearing the divider. Software reaches the block through a four-entry byte register bus with an address, write data, a write strobe and combinational read data.

Top module: `divtap_timer`

## Requirements
- R1: Register offsets are fixed. Offset 0 is the divider view, 1 is the counter, 2 is the modulo value and 3 is control. A read returns the selected register in the same cycle.
- R2: The 16-bit divider advances by one every clock and wraps from 0xFFFF to 0x0000. A read of offset 0 returns divider bits 15:8.
- R3: Any write to offset 0 clears all 16 divider bits whatever the data, so the divider reads 0 after the write edge.
- R4: Control bit 2 is the enable. Control bits 1:0 pick the divider tap: 00 picks bit 9, 01 picks bit 3, 10 picks bit 5 and 11 picks bit 7.
- R5: The counter advances by one on each 1-to-0 transition of (enable AND tap bit). Suppose the divider is cleared on one clock and the enable is written on the next clock. Then the counter reads n exactly n·2^(tap+1) clocks after the enable write edge, and reads n-1 one clock earlier.
- R6: A 1-to-0 transition of the gated signal caused by software also advances the counter. This covers clearing the enable and clearing the divider.
- R7: An advance from 0xFF loads the modulo value instead of 0x00. On that same edge the interrupt output rises, and it stays high for exactly one clock.
- R8: Write priority. An overflow reload wins over a counter write in the same cycle. A counter write wins over a plain (non-overflow) advance in the same cycle.
- R9: Writes to offsets 1, 2 and 3 store the byte. Control bits 7:3 are not stored and always read as 1, so writing 0x02 reads back 0xFA.
- R10: A synchronous reset clears the divider, counter, modulo, control, edge history and interrupt. After reset, offsets 0 to 2 read 0x00, control reads 0xF8 and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one write per asserted clock |
| rdata | output | 8 | Read data for the selected offset |
| irq | output | 1 | One-clock timer interrupt request |

## Verification
The hardest situations to reach from the ports are those where an edge event and a software write land on the same clock. One is an overflow coinciding with a counter write. Another is a control or divider write landing while the selected tap is high. The stimulus first clears the divider and then writes the enable on the next clock. This pins the divider phase exactly, so the cycle of every falling tap edge is known. The bench then counts clocks from that enable write and places the colliding write on the exact edge where the overflow or the tap high phase occurs.

// File: rtl/divtap_timer.sv
module divtap_timer #(
  parameter int DIV_W = 16,
  parameter int TAP00 = 9,
  parameter int TAP01 = 3,
  parameter int TAP10 = 5,
  parameter int TAP11 = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam int IDX_W = $clog2(DIV_W);

  logic [DIV_W-1:0] div_q;
  logic [7:0]       cnt_q, mod_q;
  logic [2:0]       ctl_q;
  logic             gate_prev_q, irq_q;
  logic [IDX_W-1:0] tap_idx;
  logic             gate_now, bump, wrap;

  wire wr_div = wr_en && (addr == 2'd0);
  wire wr_cnt = wr_en && (addr == 2'd1);
  wire wr_mod = wr_en && (addr == 2'd2);
  wire wr_ctl = wr_en && (addr == 2'd3);

  always_comb begin
    case (ctl_q[1:0])
      2'b00:   tap_idx = IDX_W'(TAP00);
      2'b01:   tap_idx = IDX_W'(TAP01);
      2'b10:   tap_idx = IDX_W'(TAP10);
      default: tap_idx = IDX_W'(TAP11);
    endcase
  end

  assign gate_now = ctl_q[2] & div_q[tap_idx];
  assign bump     = gate_prev_q & ~gate_now;
  assign wrap     = bump && (cnt_q == 8'hFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q       <= '0;
      cnt_q       <= '0;
      mod_q       <= '0;
      ctl_q       <= '0;
      gate_prev_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      div_q       <= wr_div ? '0 : div_q + 1'b1;
      gate_prev_q <= gate_now;
      irq_q       <= wrap;
      if (wrap)        cnt_q <= mod_q;
      else if (wr_cnt) cnt_q <= wdata;
      else if (bump)   cnt_q <= cnt_q + 8'd1;
      if (wr_mod) mod_q <= wdata;
      if (wr_ctl) ctl_q <= wdata[2:0];
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = div_q[DIV_W-1 -: 8];
      2'd1:    rdata = cnt_q;
      2'd2:    rdata = mod_q;
      default: rdata = {5'b11111, ctl_q};
    endcase
  end

  assign irq = irq_q;

  assert_div_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_div)) |-> div_q == $past(div_q) + 1'b1);

  assert_div_clear_R3: assert property (@(posedge clk) disable iff (rst)
    wr_div |=> div_q == '0);

  assert_cnt_source_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cnt_q != $past(cnt_q)) |-> ($past(bump) || $past(wr_cnt)));

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_reload_value_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> cnt_q == $past(mod_q));

  assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt_q == 8'd0 && div_q == '0 && !irq));
endmodule

// File: tb/tb_divtap_timer.sv
module tb_divtap_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic       wr_en = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  divtap_timer dut (.clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
                    .wr_en(wr_en), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic arm(input logic [1:0] sel, input logic [7:0] modv, input logic [7:0] cntv);
    wr(2'd3, 8'h00);
    wr(2'd2, modv);
    wr(2'd1, cntv);
    wr(2'd0, 8'h00);
    wr(2'd3, {5'b0, 1'b1, sel});
  endtask

  task automatic t_reset(input string tag);
    logic [7:0] v;
    rd(2'd0, v); check({tag, " R10 div"}, v, 8'h00);
    rd(2'd1, v); check({tag, " R10 cnt"}, v, 8'h00);
    rd(2'd2, v); check({tag, " R10 mod"}, v, 8'h00);
    rd(2'd3, v); check({tag, " R10 ctl"}, v, 8'hF8);
    check({tag, " R10 irq"}, irq, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(2'd2, 8'h5A); rd(2'd2, v); check("R9 R1 modulo store", v, 8'h5A);
    wr(2'd3, 8'hFF); rd(2'd3, v); check("R9 ctl all ones", v, 8'hFF);
    wr(2'd3, 8'h02); rd(2'd3, v); check("R9 ctl high bits", v, 8'hFA);
    wr(2'd1, 8'hC3); rd(2'd1, v); check("R9 R1 counter store", v, 8'hC3);
  endtask

  task automatic t_divider();
    logic [7:0] v;
    wr(2'd0, 8'hAB); rd(2'd0, v); check("R3 clear ignores data", v, 8'h00);
    repeat (600) tick();
    rd(2'd0, v); check("R2 upper byte", v, 8'h02);
    wr(2'd0, 8'h00);
    repeat (300) tick();
    rd(2'd0, v); check("R2 before wrap", v, 8'h01);
    repeat (65536) tick();
    rd(2'd0, v); check("R2 full period", v, 8'h01);
    repeat (65236) tick();
    rd(2'd0, v); check("R2 wrap to zero", v, 8'h00);
  endtask

  task automatic t_rate(input logic [1:0] sel, input int bitn);
    logic [7:0] v;
    int p = 1 << (bitn + 1);
    arm(sel, 8'h00, 8'h00);
    repeat (p - 1) tick();
    rd(2'd1, v); check($sformatf("R4 R5 sel%0d before edge", sel), v, 0);
    tick();
    rd(2'd1, v); check($sformatf("R4 R5 sel%0d first edge", sel), v, 1);
    repeat (3 * p) tick();
    rd(2'd1, v); check($sformatf("R4 R5 sel%0d four edges", sel), v, 4);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    arm(2'b01, 8'hF0, 8'hFE);
    repeat (15) tick();
    rd(2'd1, v); check("R7 still FE", v, 8'hFE);
    tick();
    rd(2'd1, v); check("R7 at FF", v, 8'hFF);
    check("R7 no irq at FF", irq, 0);
    repeat (15) tick();
    check("R7 irq low before wrap", irq, 0);
    tick();
    rd(2'd1, v); check("R7 reload from modulo", v, 8'hF0);
    check("R7 irq high", irq, 1);
    tick();
    check("R7 irq one cycle", irq, 0);
  endtask

  task automatic t_priority();
    logic [7:0] v;
    arm(2'b01, 8'hA5, 8'hFE);
    repeat (31) tick();
    wr(2'd1, 8'h33);
    rd(2'd1, v); check("R8 reload beats write", v, 8'hA5);
    check("R8 irq with collision", irq, 1);
    arm(2'b01, 8'h00, 8'h10);
    repeat (15) tick();
    wr(2'd1, 8'h40);
    rd(2'd1, v); check("R8 write beats advance", v, 8'h40);
    repeat (15) tick();
    rd(2'd1, v); check("R8 held until next edge", v, 8'h40);
    tick();
    rd(2'd1, v); check("R8 advances after", v, 8'h41);
  endtask

  task automatic t_sw_edges();
    logic [7:0] v;
    arm(2'b01, 8'h00, 8'h00);
    repeat (10) tick();
    wr(2'd3, 8'h01);
    rd(2'd1, v); check("R6 disable before count", v, 0);
    tick();
    rd(2'd1, v); check("R6 disable counts", v, 1);
    repeat (40) tick();
    rd(2'd1, v); check("R6 disabled holds", v, 1);
    arm(2'b01, 8'h00, 8'h00);
    repeat (10) tick();
    wr(2'd0, 8'h77);
    tick();
    rd(2'd1, v); check("R6 divider clear counts", v, 1);
    repeat (15) tick();
    rd(2'd1, v); check("R6 R5 realigned hold", v, 1);
    tick();
    rd(2'd1, v); check("R6 R5 realigned edge", v, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset("init");
    rst = 1'b0;
    t_regs();
    t_divider();
    t_rate(2'b00, 9);
    t_rate(2'b01, 3);
    t_rate(2'b10, 5);
    t_rate(2'b11, 7);
    t_overflow();
    t_priority();
    t_sw_edges();
    arm(2'b01, 8'h3C, 8'h20);
    repeat (20) tick();
    rst = 1'b1;
    repeat (2) tick();
    t_reset("midrun");
    rst = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(190000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule